// File: doc/BRIEF.md
# Processor Status Flag Register

This block holds the condition and power-management flags of a small 8-bit processor core. It has four arithmetic flags: carry, half carry, zero and overflow. The ALU updates them one flag at a time through per-flag enables, and software can also write them as an ordinary data register.

It also has two power-management flags: a sleep marker and a watchdog-expiry marker. These flags cannot be written by software. Each one moves only on its own events: power-up reset, the halt instruction, the watchdog-clear instruction, and a watchdog expiry pulse. The read value is driven straight from the flag registers.

The register is not saved automatically. Firmware that calls a subroutine or enters an interrupt must save and restore it if the contents matter. All inputs are plain control pins sampled on the rising clock edge, and there is no handshake.

Top module: `status_flag_reg`

## Requirements
- R1: While `rst_n` is low, and on the first clock after it is released, `stat_q` reads 8'h00.
- R2: Bits 7 and 6 of `stat_q` always read 0, whatever is written.
- R3: The bit layout is carry at bit 0, half carry at bit 1, zero at bit 2, overflow at bit 3, sleep flag at bit 4 and watchdog-expiry flag at bit 5. When `alu_upd_en[i]` (i = 0..3) is high, arithmetic flag i takes `alu_flag_in[i]` on that clock edge. Flags whose enable is low keep their value.
- R4: A cycle with `sw_wr_en` high loads `sw_wr_data[3:0]` into the arithmetic flags whose ALU enable is low.
- R5: A software write never changes bit 4 or bit 5.
- R6: When a software write and an ALU update fall in the same cycle, each flag with its ALU enable high takes the ALU value, and the other arithmetic flags take the written bits.
- R7: `halt_pulse` sets the sleep flag (bit 4). `clr_wdt_pulse` clears it. When both are high, the flag ends up set.
- R8: `clr_wdt_pulse` or `halt_pulse` clears the watchdog-expiry flag (bit 5), and `wdt_expire` sets it.
- R9: When `wdt_expire` coincides with `clr_wdt_pulse` or `halt_pulse`, bit 5 ends up set.
- R10: In a cycle with no enable, write or event input high, `stat_q` keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-up reset, active low, asynchronous |
| alu_upd_en | input | 4 | Per-flag ALU update enables, bit i for flag i |
| alu_flag_in | input | 4 | ALU flag values, same bit order as `stat_q[3:0]` |
| sw_wr_en | input | 1 | Software write strobe |
| sw_wr_data | input | 8 | Software write data; only bits 3:0 are used |
| halt_pulse | input | 1 | Halt instruction executed |
| clr_wdt_pulse | input | 1 | Watchdog-clear instruction executed |
| wdt_expire | input | 1 | Watchdog time-out event |
| stat_q | output | 8 | Register read value |

## Verification
Two pairs of functions can land in the same clock. The first is an ALU flag update with a software write. The second is a watchdog expiry with a watchdog-clear or halt. The bench provokes each collision on purpose: it sets both strobes in one cycle with partial ALU enables and with conflicting power events. It then judges the per-flag result against the priority rules in R6, R7 and R9. A long stretch of random stimulus then mixes all inputs, and a behavioural model checks `stat_q` on every clock.

// File: rtl/stat_pkg.sv
package stat_pkg;
  localparam int unsigned STAT_W      = 8;
  localparam int unsigned ARITH_FLAGS = 4;
  localparam int unsigned POS_C       = 0;
  localparam int unsigned POS_HC      = 1;
  localparam int unsigned POS_Z       = 2;
  localparam int unsigned POS_OV      = 3;
  localparam int unsigned POS_SLEEP   = 4;
  localparam int unsigned POS_WDTO    = 5;

  typedef struct packed {
    logic halt;
    logic clr_wdt;
    logic expire;
  } pwr_evt_t;
endpackage

// File: rtl/stat_arith_bank.sv
module stat_arith_bank #(
  parameter int unsigned NFLAG = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NFLAG-1:0] alu_en,
  input  logic [NFLAG-1:0] alu_val,
  input  logic             sw_we,
  input  logic [NFLAG-1:0] sw_val,
  output logic [NFLAG-1:0] flags_q
);
  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    logic bit_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          bit_q <= 1'b0;
      else if (alu_en[i])  bit_q <= alu_val[i];
      else if (sw_we)      bit_q <= sw_val[i];
    end
    assign flags_q[i] = bit_q;
  end
endmodule

// File: rtl/stat_pwr_flags.sv
module stat_pwr_flags
  import stat_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  pwr_evt_t evt,
  output logic     sleep_q,
  output logic     wdto_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           sleep_q <= 1'b0;
    else if (evt.halt)    sleep_q <= 1'b1;
    else if (evt.clr_wdt) sleep_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        wdto_q <= 1'b0;
    else if (evt.expire)               wdto_q <= 1'b1;
    else if (evt.clr_wdt || evt.halt)  wdto_q <= 1'b0;
  end
endmodule

// File: rtl/status_flag_reg.sv
module status_flag_reg
  import stat_pkg::*;
#(
  parameter int unsigned DATA_W  = STAT_W,
  parameter int unsigned N_ARITH = ARITH_FLAGS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_ARITH-1:0] alu_upd_en,
  input  logic [N_ARITH-1:0] alu_flag_in,
  input  logic               sw_wr_en,
  input  logic [DATA_W-1:0]  sw_wr_data,
  input  logic               halt_pulse,
  input  logic               clr_wdt_pulse,
  input  logic               wdt_expire,
  output logic [DATA_W-1:0]  stat_q
);
  localparam int unsigned SPARE_LO = N_ARITH;

  logic [N_ARITH-1:0] arith_q;
  logic               sleep_q;
  logic               wdto_q;
  pwr_evt_t           evt;
  logic               unused_wr_hi;

  assign unused_wr_hi = ^sw_wr_data[DATA_W-1:SPARE_LO];
  assign evt = '{halt: halt_pulse, clr_wdt: clr_wdt_pulse, expire: wdt_expire};

  stat_arith_bank #(.NFLAG(N_ARITH)) u_arith (
    .clk     (clk),
    .rst_n   (rst_n),
    .alu_en  (alu_upd_en),
    .alu_val (alu_flag_in),
    .sw_we   (sw_wr_en),
    .sw_val  (sw_wr_data[N_ARITH-1:0]),
    .flags_q (arith_q)
  );

  stat_pwr_flags u_pwr (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt     (evt),
    .sleep_q (sleep_q),
    .wdto_q  (wdto_q)
  );

  always_comb begin
    stat_q                = '0;
    stat_q[N_ARITH-1:0]   = arith_q;
    stat_q[POS_SLEEP]     = sleep_q;
    stat_q[POS_WDTO]      = wdto_q;
  end
endmodule

// File: rtl/status_flag_chk.sv
module status_flag_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] alu_upd_en,
  input logic [3:0] alu_flag_in,
  input logic       sw_wr_en,
  input logic       halt_pulse,
  input logic       clr_wdt_pulse,
  input logic       wdt_expire,
  input logic [7:0] stat_q
);
  // R2
  spare_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_q[7:6] == 2'b00);

  // R3
  alu_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_upd_en != 4'h0) |=>
      ((stat_q[3:0] & $past(alu_upd_en)) == ($past(alu_flag_in) & $past(alu_upd_en))));

  // R5
  sw_pwr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_wr_en && !halt_pulse && !clr_wdt_pulse && !wdt_expire) |=>
      (stat_q[5:4] == $past(stat_q[5:4])));

  // R7
  halt_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt_pulse |=> stat_q[4]);

  // R7
  clr_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wdt_pulse && !halt_pulse) |=> !stat_q[4]);

  // R9
  expire_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_expire |=> stat_q[5]);

  // R8
  wdto_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_wdt_pulse || halt_pulse) && !wdt_expire) |=> !stat_q[5]);

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_upd_en == 4'h0 && !sw_wr_en && !halt_pulse && !clr_wdt_pulse && !wdt_expire)
      |=> $stable(stat_q));
endmodule

bind status_flag_reg status_flag_chk u_chk (.*);

// File: tb/status_flag_reg_bench.sv
module status_flag_reg_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] alu_upd_en = '0;
  logic [3:0] alu_flag_in = '0;
  logic       sw_wr_en = 1'b0;
  logic [7:0] sw_wr_data = '0;
  logic       halt_pulse = 1'b0;
  logic       clr_wdt_pulse = 1'b0;
  logic       wdt_expire = 1'b0;
  logic [7:0] stat_q;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit started = 0;
  bit reported = 0;
  string cur_req = "R1";
  logic [7:0] model = 8'h00;

  always #10 clk = ~clk;

  status_flag_reg u_status_flag_reg (.*);

  function automatic logic [7:0] model_next(logic [7:0] cur);
    logic [7:0] n;
    n = cur;
    for (int i = 0; i < 4; i++) begin
      if (alu_upd_en[i]) n[i] = alu_flag_in[i];
      else if (sw_wr_en) n[i] = sw_wr_data[i];
    end
    if (halt_pulse) n[4] = 1'b1;
    else if (clr_wdt_pulse) n[4] = 1'b0;
    if (wdt_expire) n[5] = 1'b1;
    else if (halt_pulse || clr_wdt_pulse) n[5] = 1'b0;
    n[7:6] = 2'b00;
    return n;
  endfunction

  always @(posedge clk) begin
    cycles <= cycles + 1;
    started <= 1'b1;
    if (!rst_n) model <= 8'h00;
    else model <= model_next(model);
  end

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  always @(negedge clk) begin
    if (started) begin
      checks++;
      if (stat_q !== model) begin
        fails++;
        $display("FAIL %s per-cycle model: actual %h expected %h", cur_req, stat_q, model);
      end
    end
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      report();
    end
  end

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(logic [3:0] en, logic [3:0] fl, logic we, logic [7:0] wd,
                      logic h, logic c, logic t);
    alu_upd_en = en; alu_flag_in = fl; sw_wr_en = we; sw_wr_data = wd;
    halt_pulse = h; clr_wdt_pulse = c; wdt_expire = t;
    @(negedge clk);
    alu_upd_en = '0; alu_flag_in = '0; sw_wr_en = 0; sw_wr_data = '0;
    halt_pulse = 0; clr_wdt_pulse = 0; wdt_expire = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", stat_q, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", stat_q, 8'h00);

    cur_req = "R3";
    step(4'b0101, 4'b1111, 0, 8'h00, 0, 0, 0);
    chk("R3", stat_q, 8'h05);
    step(4'b1010, 4'b1010, 0, 8'h00, 0, 0, 0);
    chk("R3", stat_q, 8'h0F);
    step(4'b0001, 4'b0000, 0, 8'h00, 0, 0, 0);
    chk("R3", stat_q, 8'h0E);

    cur_req = "R4";
    step(4'b0000, 4'b0000, 1, 8'hF3, 0, 0, 0);
    chk("R4", stat_q, 8'h03);
    chk("R2", {6'h0, stat_q[7:6]}, 8'h00);

    cur_req = "R7";
    step(4'b0000, 4'b0000, 0, 8'h00, 1, 0, 0);
    chk("R7", stat_q, 8'h13);

    cur_req = "R5";
    step(4'b0000, 4'b0000, 1, 8'h00, 0, 0, 0);
    chk("R5", stat_q, 8'h10);
    step(4'b0000, 4'b0000, 1, 8'hFF, 0, 0, 0);
    chk("R5", stat_q, 8'h1F);

    cur_req = "R8";
    step(4'b0000, 4'b0000, 0, 8'h00, 0, 0, 1);
    chk("R8", stat_q, 8'h3F);
    step(4'b0000, 4'b0000, 0, 8'h00, 0, 1, 0);
    chk("R8", stat_q, 8'h0F);
    step(4'b0000, 4'b0000, 0, 8'h00, 0, 0, 1);
    step(4'b0000, 4'b0000, 0, 8'h00, 1, 0, 0);
    chk("R8", stat_q, 8'h1F);

    cur_req = "R9";
    step(4'b0000, 4'b0000, 0, 8'h00, 0, 1, 1);
    chk("R9", stat_q, 8'h2F);
    step(4'b0000, 4'b0000, 0, 8'h00, 1, 0, 1);
    chk("R9", stat_q, 8'h3F);

    cur_req = "R7";
    step(4'b0000, 4'b0000, 0, 8'h00, 1, 1, 0);
    chk("R7", stat_q, 8'h1F);

    cur_req = "R6";
    step(4'b0101, 4'b0000, 1, 8'hFF, 0, 0, 0);
    chk("R6", stat_q, 8'h1A);
    step(4'b1000, 4'b1000, 1, 8'h00, 0, 0, 0);
    chk("R6", stat_q, 8'h18);

    cur_req = "R10";
    repeat (4) @(negedge clk);
    chk("R10", stat_q, 8'h18);

    cur_req = "R6";
    for (int k = 0; k < 600; k++) begin
      logic [31:0] r;
      r = $urandom;
      step(r[3:0], r[7:4], r[8], r[23:16], r[9] & r[10], r[11] & r[12], r[13] & r[14]);
    end

    cur_req = "R1";
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1", stat_q, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    report();
  end
endmodule